// File: doc/BRIEF.md
# Match-Compare Timer with Clear-on-Match

This block is an up-counting timer with one compare register. A small word-addressed register port lets software set a compare value, read the running count, start and stop the counter, choose whether the counter restarts from zero when it meets the compare value, and zero the count. When the running counter equals the compare value, the block raises a one-clock expiry pulse. An interrupt controller set to rising-edge detection consumes this pulse.

The comparison is exact equality. A compare value that the counter has already passed fires only after the counter wraps around. Software that arms a short delay therefore reads the count again after arming it, to detect that it armed the timer too late. A parameter selects the readout used for timekeeping. With zero the side output carries the raw count. With a non-zero value the block runs on a fast clock, and the side output is the count with that many low bits dropped.

Top module: `match_timer`

## Requirements
- R1: After a synchronous active-low reset the count reads 0, the compare word reads all ones, the control word reads 0 and the expiry output is low.
- R2: While control bit 0 (run) is set, the count rises by exactly one on every clock.
- R3: While the run bit is clear, the count keeps its value.
- R4: Any write to word slot 3 (byte offset 0xC) zeroes the count on the next clock. This applies whether the counter is running or stopped, and takes priority over counting.
- R5: The expiry output is high for one clock. It rises in the cycle after the one in which the running count equals the compare value. An equality that lasts several cycles yields a single pulse.
- R6: With control bit 1 (wrap) set and the counter running, a count equal to the compare value is followed by 0 instead of the incremented value. With bit 1 clear, counting continues past the compare value.
- R7: No expiry pulse is produced while the run bit is clear, even when the count equals the compare value.
- R8: A compare value lower than the current count does not fire until the counter has wrapped past zero and reaches it again.
- R9: A write to word slot 0 (byte offset 0x0) updates the compare value on the next clock, and the comparison in the cycle that follows uses the new value.
- R10: Reads of word slot 1 (byte offset 0x4) return the live count, and writes to that slot leave the count unchanged.
- R11: The side output `tick_o` equals the count shifted right by READ_SHIFT bits.
- R12: Word slot 2 (byte offset 0x8) reads back the run bit in bit 0 and the wrap bit in bit 1, with all other bits zero. Word slot 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the slot selected by bus_addr |
| bus_addr | input | 2 | Word slot, i.e. byte address bits 3:2 (0 compare, 1 count, 2 control, 3 clear) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data of the selected slot |
| tick_o | output | CNT_W-READ_SHIFT | Count shifted right by READ_SHIFT |
| expire_o | output | 1 | One-clock expiry pulse |

## Verification
The timer is driven through several patterns. A plain run and stop shows the difference between counting and holding. A clear written while running and while stopped shows that the clear wins over the increment. Wrap mode with a mid-range compare value gives a periodic pulse train, and wrap mode with compare value 0 gives a held equality that must produce only one pulse. A compare value written as the count reaches it separates the next-clock update from a delayed one. A compare value below the count shows, over a full counter wrap of a 16-bit build, that a late setting stays silent until wraparound. A behavioural model in the bench is compared with the pulse and the shifted readout on every clock.

// File: rtl/mt_pkg.sv
// Shared definitions for the match-compare timer: word slots of the
// register port and bit positions inside the control word.
package mt_pkg;
    // Word slot decoded from byte address bits 3:2.
    typedef enum logic [1:0] {
        SLOT_MATCH = 2'd0,
        SLOT_COUNT = 2'd1,
        SLOT_CTRL  = 2'd2,
        SLOT_CLEAR = 2'd3
    } mt_slot_e;

    localparam int RUN_BIT  = 0;
    localparam int WRAP_BIT = 1;
endpackage

// File: rtl/mt_regs.sv
// Register slots of the timer: the compare value and the two control bits,
// plus the clear strobe and the read multiplexer.
// Assumes a single-cycle write strobe and a purely combinational read.
module mt_regs #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_slot,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] match_val,
    output logic             run_en,
    output logic             wrap_en,
    output logic             clr_req,
    output logic [CNT_W-1:0] bus_rdata
);
    import mt_pkg::*;

    mt_slot_e slot;
    assign slot = mt_slot_e'(bus_slot);

    // Clear strobe: any write to the clear slot, whatever the data.
    assign clr_req = bus_wr && (slot == SLOT_CLEAR);

    // Compare value: all ones after reset, loaded by a write to its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_val <= '1;
        end else if (bus_wr && (slot == SLOT_MATCH)) begin
            match_val <= bus_wdata;
        end
    end

    // Control bits: both off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            wrap_en <= 1'b0;
        end else if (bus_wr && (slot == SLOT_CTRL)) begin
            run_en  <= bus_wdata[RUN_BIT];
            wrap_en <= bus_wdata[WRAP_BIT];
        end
    end

    // Read multiplexer over the four slots.
    always_comb begin
        bus_rdata = '0;
        case (slot)
            SLOT_MATCH: bus_rdata = match_val;
            SLOT_COUNT: bus_rdata = cnt_val;
            SLOT_CTRL: begin
                bus_rdata[RUN_BIT]  = run_en;
                bus_rdata[WRAP_BIT] = wrap_en;
            end
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mt_counter.sv
// Free-running up-counter. A clear request wins over counting. When running,
// the counter restarts from zero on a match if wrap is enabled and otherwise
// increments, rolling over naturally at its width.
// Assumes at_match is the combinational equality of the current count.
module mt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wrap_en,
    input  logic             clr_req,
    input  logic             at_match,
    output logic [CNT_W-1:0] cnt_val
);
    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_val <= '0;
        end else if (clr_req) begin
            cnt_val <= '0;
        end else if (run_en) begin
            if (wrap_en && at_match) begin
                cnt_val <= '0;
            end else begin
                cnt_val <= cnt_val + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mt_compare.sv
// Exact-equality comparator and expiry pulse former. The pulse is registered
// and marks the rising edge of (running && count == compare), so an equality
// held for several cycles gives one pulse.
module mt_compare #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             run_en,
    output logic             at_match,
    output logic             expire_o
);
    logic hit;
    logic hit_q;

    assign at_match = (cnt_val == match_val);
    assign hit      = run_en && at_match;

    // Edge detect on the qualified hit; the output is one clock long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= 1'b0;
            expire_o <= 1'b0;
        end else begin
            hit_q    <= hit;
            expire_o <= hit && !hit_q;
        end
    end
endmodule

// File: rtl/match_timer.sv
// Top of the match-compare timer: a register port, a counter and a comparator.
// READ_SHIFT picks the side readout: 0 exposes the raw count, a positive
// value drops that many low bits for a fast-clock build.
module match_timer #(
    parameter int CNT_W      = 32,
    parameter int READ_SHIFT = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [3:2]                  bus_addr,
    input  logic [CNT_W-1:0]            bus_wdata,
    output logic [CNT_W-1:0]            bus_rdata,
    output logic [CNT_W-READ_SHIFT-1:0] tick_o,
    output logic                        expire_o
);
    localparam int TICK_W = CNT_W - READ_SHIFT;

    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] match_val;
    logic             run_en;
    logic             wrap_en;
    logic             clr_req;
    logic             at_match;

    mt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_slot  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_val),
        .match_val (match_val),
        .run_en    (run_en),
        .wrap_en   (wrap_en),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    mt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .wrap_en  (wrap_en),
        .clr_req  (clr_req),
        .at_match (at_match),
        .cnt_val  (cnt_val)
    );

    mt_compare #(.CNT_W(CNT_W)) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .match_val (match_val),
        .run_en    (run_en),
        .at_match  (at_match),
        .expire_o  (expire_o)
    );

    // Side readout: raw count or count with the low bits dropped.
    generate
        if (READ_SHIFT == 0) begin : g_raw
            assign tick_o = cnt_val;
        end else begin : g_shifted
            assign tick_o = TICK_W'(cnt_val >> READ_SHIFT);
        end
    endgenerate
endmodule

// File: rtl/mt_checker.sv
// Temporal checks on the timer, bound into match_timer.
module mt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_slot,
    input logic             run_en,
    input logic             wrap_en,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] match_val,
    input logic             expire_o
);
    logic clr;
    assign clr = bus_wr && (bus_slot == 2'd3);

    // R2: a running counter with no clear and no wrap advances by one.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !clr && !(wrap_en && cnt_val == match_val))
        |=> (cnt_val == $past(cnt_val) + 1'b1));

    // R3: a stopped counter with no clear holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr) |=> $stable(cnt_val));

    // R4: the clear slot zeroes the count.
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_val == '0));

    // R5: the expiry pulse never lasts two clocks.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

    // R6: wrap mode restarts from zero on a match.
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wrap_en && !clr && cnt_val == match_val) |=> (cnt_val == '0));

    // R7: a pulse is only produced after a cycle in which the counter ran.
    assert_pulse_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expire_o) |-> $past(run_en));
endmodule

bind match_timer mt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_slot  (bus_addr),
    .run_en    (run_en),
    .wrap_en   (wrap_en),
    .cnt_val   (cnt_val),
    .match_val (match_val),
    .expire_o  (expire_o)
);

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
    localparam int W  = 16;
    localparam int SH = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bwr = 1'b0;
    logic [1:0]    baddr = 2'd0;
    logic [W-1:0]  bwdata = '0;
    logic [W-1:0]  rdata;
    logic [W-SH-1:0] tick;
    logic          expire;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cyc    = 0;

    // Reference model state
    logic [W-1:0] m_count = '0;
    logic [W-1:0] m_match = '1;
    logic         m_run = 1'b0, m_wrap = 1'b0, m_hitq = 1'b0, m_exp = 1'b0;
    logic         m_hit;
    logic [W-1:0] m_next;

    always #2 clk = ~clk;   // 250 MHz

    match_timer #(.CNT_W(W), .READ_SHIFT(SH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(baddr),
        .bus_wdata(bwdata), .bus_rdata(rdata), .tick_o(tick), .expire_o(expire)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model, updated on the same edge the design samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = '0; m_match = '1; m_run = 0; m_wrap = 0; m_hitq = 0; m_exp = 0;
        end else begin
            m_hit  = m_run && (m_count == m_match);
            m_exp  = m_hit && !m_hitq;
            m_hitq = m_hit;
            m_next = m_count;
            if (bwr && baddr == 2'd3)       m_next = '0;
            else if (m_run && m_wrap && m_count == m_match) m_next = '0;
            else if (m_run)                 m_next = m_count + 1'b1;
            m_count = m_next;
            if (bwr && baddr == 2'd0) m_match = bwdata;
            if (bwr && baddr == 2'd2) begin m_run = bwdata[0]; m_wrap = bwdata[1]; end
        end
    end

    always @(posedge clk) if (rst_n && expire === 1'b1) pulses++;

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 R7 expire pulse", {31'b0, expire}, {31'b0, m_exp});
            chk("R11 shifted tick", 32'(tick), 32'(m_count >> SH));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); bwr = 1'b1; baddr = a; bwdata = d;
        @(negedge clk); bwr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        @(negedge clk); baddr = a; #1; v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] v, v2;
        int p0;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); chk("R1 count after reset", 32'(v), 32'h0);
        rd(2'd0, v); chk("R1 compare after reset", 32'(v), 32'hFFFF);
        rd(2'd2, v); chk("R1 control after reset", 32'(v), 32'h0);
        chk("R1 expire after reset", {31'b0, expire}, 32'h0);

        // R10 write to count slot is ignored
        wr(2'd1, 16'h1234);
        rd(2'd1, v); chk("R10 count write ignored", 32'(v), 32'h0);

        // R2 running
        wr(2'd2, 16'h1);
        idle(30);
        rd(2'd1, v); chk("R2 R10 live count", 32'(v), 32'(m_count));
        idle(1);
        rd(2'd1, v2); chk("R2 step over two clocks", 32'(v2), 32'(v + 16'd2));

        // R3 stop and hold
        wr(2'd2, 16'h0);
        rd(2'd1, v); idle(10);
        rd(2'd1, v2); chk("R3 count holds when stopped", 32'(v2), 32'(v));

        // R4 clear while stopped and while running
        wr(2'd3, 16'hBEEF);
        rd(2'd1, v); chk("R4 clear while stopped", 32'(v), 32'h0);
        wr(2'd2, 16'h1); idle(7);
        wr(2'd3, 16'h0);
        rd(2'd1, v); chk("R4 clear beats increment", 32'(v), 32'(m_count));

        // R12 control readback and clear slot read
        wr(2'd2, 16'h2);
        rd(2'd2, v); chk("R12 control readback", 32'(v), 32'h2);
        rd(2'd3, v); chk("R12 clear slot reads zero", 32'(v), 32'h0);

        // R7 stopped with count equal to compare: no pulse
        wr(2'd2, 16'h0); wr(2'd3, 16'h0); wr(2'd0, 16'h0);
        idle(3); p0 = pulses; idle(10);
        chk("R7 no pulse while stopped", 32'(pulses - p0), 32'h0);

        // R5 held equality (wrap with compare 0) gives one pulse
        p0 = pulses;
        wr(2'd2, 16'h3); idle(20);
        chk("R5 single pulse on held equality", 32'(pulses - p0), 32'h1);
        rd(2'd1, v); chk("R6 count pinned at zero", 32'(v), 32'h0);

        // R6 periodic wrap with compare 9
        wr(2'd2, 16'h0); wr(2'd3, 16'h0); wr(2'd0, 16'd9);
        idle(3); p0 = pulses;
        wr(2'd2, 16'h3); idle(100);
        chk("R6 periodic pulses", 32'(pulses - p0 >= 9), 32'h1);
        rd(2'd1, v); chk("R6 count stays within period", 32'(v <= 16'd9), 32'h1);

        // R6 without wrap: count runs past compare, one pulse
        wr(2'd2, 16'h0); wr(2'd3, 16'h0); wr(2'd0, 16'd5);
        idle(3); p0 = pulses;
        wr(2'd2, 16'h1); idle(20);
        rd(2'd1, v); chk("R6 count passes compare", 32'(v > 16'd5), 32'h1);
        chk("R5 one pulse per match", 32'(pulses - p0), 32'h1);

        // R9 compare written to the value the count reaches on the same edge
        wr(2'd2, 16'h0); wr(2'd3, 16'h0); wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'h1); idle(5);
        p0 = pulses;
        @(negedge clk); bwr = 1'b1; baddr = 2'd0; bwdata = m_count + 16'd1;
        @(negedge clk); bwr = 1'b0;
        idle(10);
        chk("R9 new compare used next cycle", 32'(pulses - p0), 32'h1);

        // R8 late compare fires only after wraparound
        wr(2'd2, 16'h0); wr(2'd3, 16'h0); wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'h1); idle(1000);
        wr(2'd0, 16'd500);
        p0 = pulses; idle(2000);
        chk("R8 passed compare silent", 32'(pulses - p0), 32'h0);
        idle(65000);
        chk("R8 fires after wrap", 32'(pulses - p0), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule